// File: doc/BRIEF.md
# Extended Control Register Window with Test FIFO

This block is a second register window of eight byte locations for a parallel port that can run extended modes. The host reaches it through a 3-bit offset, a byte of write data, a write strobe and a read strobe. Read data is combinational from the current state. Every side effect of an access (register update, FIFO push, FIFO pop) takes place at the rising clock edge on which the strobe is high.

The window holds three things. The extended control register (ECR) carries the operating mode in its upper three bits and the FIFO status in its lower two. A configuration byte sits at offset 1. A data location sits at offset 0. When the mode field selects FIFO test, the data location becomes a small FIFO that the host can fill and drain. In every other mode it is a plain byte register. Any write that changes the mode field flushes the FIFO. Nothing here drives a cable, DMA or an interrupt.

Top module: `ecpx_regwin`

## Requirements
- R1: After reset the ECR reads 0x01 (mode 0, empty set, full clear), and offsets 0 and 1 read 0x00.
- R2: The ECR is read at offset 2. Bits 7:5 hold the mode (0 standard, 1 byte, 2 parallel FIFO, 3 extended FIFO, 4 enhanced, 5 reserved, 6 FIFO test, 7 configuration). Bits 4:2 hold the last written value. Bit 1 is full and bit 0 is empty, so the status reads 01 when empty, 10 when full and 00 when partly filled.
- R3: In mode 6, a write to offset 0 stores the byte at the write pointer and advances the pointer. When the advance reaches the depth, the pointer wraps to zero and the status becomes full (10). Otherwise the status becomes 00. This also holds for a write while full, which overwrites the oldest slot.
- R4: In mode 6, a read of offset 0 while the FIFO is not empty returns the byte at the read pointer and advances the pointer, wrapping at the depth. The status becomes empty (01) if the read pointer now equals the write pointer, and 00 otherwise. Bytes come out in the order they were written.
- R5: In mode 6, a read of offset 0 while empty returns the byte at the read pointer and changes neither pointer nor status.
- R6: A write to offset 2 whose bits 7:5 differ from the current mode resets both pointers, sets the status to empty (01) and installs the new mode.
- R7: A write to offset 2 with an unchanged mode field leaves the FIFO contents, pointers and status as they were, and updates only bits 4:2.
- R8: Outside mode 6, offset 0 is a byte register that reads back the last value written there, and accesses to it leave the FIFO untouched.
- R9: Offset 1 is a read/write configuration byte.
- R10: Reads of offsets 3 to 7 return 0xFF, and writes to them change no readable state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Window offset |
| wr_en | input | 1 | Write strobe, one access per cycle high |
| wdata | input | 8 | Write byte |
| rd_en | input | 1 | Read strobe, triggers a FIFO pop in mode 6 at offset 0 |
| rd_data | output | 8 | Read byte for the current offset, combinational |

## Verification
A read returns its value in the same cycle as the strobe, because rd_data is decoded from the registered state. Any pop, push, flag change or mode change becomes visible from the cycle after the strobed edge. The bench therefore drives each access just after a falling edge and samples rd_data two nanoseconds later, before the rising edge that commits the access. The next access then observes the committed state one cycle on. A bench-side model follows each committed access and provides every expected byte, including the flag sequence empty, one entry, full, one pop, two pops, and the stale slot returned by an empty read.

// File: rtl/ecpx_pkg.sv
package ecpx_pkg;

    localparam int BYTE_W = 8;
    localparam int OFS_W  = 3;
    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        MODE_STD  = 3'd0,
        MODE_BYTE = 3'd1,
        MODE_PPF  = 3'd2,
        MODE_XF   = 3'd3,
        MODE_ENH  = 3'd4,
        MODE_RSVD = 3'd5,
        MODE_TEST = 3'd6,
        MODE_CFG  = 3'd7
    } ecpx_mode_e;

    localparam logic [OFS_W-1:0] OFS_DATA = 3'd0;
    localparam logic [OFS_W-1:0] OFS_CFGB = 3'd1;
    localparam logic [OFS_W-1:0] OFS_ECR  = 3'd2;

    localparam logic [BYTE_W-1:0] IDLE_BYTE = 8'hFF;

    typedef struct packed {
        ecpx_mode_e        mode;
        logic [2:0]        ctl;
        logic [BYTE_W-1:0] cfgb;
        logic [BYTE_W-1:0] dat;
    } ecpx_regs_t;

endpackage

// File: rtl/ecpx_fifo.sv
module ecpx_fifo #(
    parameter int DEPTH = 2,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] wbyte,
    output logic [DW-1:0] rbyte,
    output logic          empty,
    output logic          full
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [PW-1:0]            wp;
        logic [PW-1:0]            rp;
        logic                     empty;
        logic                     full;
    } fifo_st_t;

    fifo_st_t s_d, s_q;
    logic [PW-1:0] rp_nx;

    always_comb begin
        s_d   = s_q;
        rp_nx = (s_q.rp == LAST) ? '0 : s_q.rp + 1'b1;
        if (flush) begin
            s_d.wp    = '0;
            s_d.rp    = '0;
            s_d.empty = 1'b1;
            s_d.full  = 1'b0;
        end else if (push) begin
            s_d.mem[s_q.wp] = wbyte;
            s_d.empty       = 1'b0;
            if (s_q.wp == LAST) begin
                s_d.wp   = '0;
                s_d.full = 1'b1;
            end else begin
                s_d.wp   = s_q.wp + 1'b1;
                s_d.full = 1'b0;
            end
        end else if (pop && !s_q.empty) begin
            s_d.rp    = rp_nx;
            s_d.empty = (rp_nx == s_q.wp);
            s_d.full  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.empty <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign rbyte = s_q.mem[s_q.rp];
    assign empty = s_q.empty;
    assign full  = s_q.full;

    // R2: the two status bits never both read one
    p_flags_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_q.empty && s_q.full));

    // R6: a flush leaves both pointers at zero with empty status
    p_flush_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (s_q.empty && !s_q.full && s_q.wp == '0 && s_q.rp == '0));

    // R3: a push always leaves the FIFO non-empty
    p_push_nonempty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !flush) |=> !s_q.empty);

    // R5: a pop on an empty FIFO moves nothing
    p_empty_pop_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !flush && s_q.empty) |=> ($stable(s_q.rp) && $stable(s_q.wp) && s_q.empty));

endmodule

// File: rtl/ecpx_rdmux.sv
module ecpx_rdmux
    import ecpx_pkg::*;
(
    input  logic [OFS_W-1:0]  addr,
    input  logic              test_mode,
    input  logic [BYTE_W-1:0] ecr,
    input  logic [BYTE_W-1:0] cfgb,
    input  logic [BYTE_W-1:0] plain,
    input  logic [BYTE_W-1:0] fifo_byte,
    output logic [BYTE_W-1:0] rd_data
);

    always_comb begin
        unique case (addr)
            OFS_DATA: rd_data = test_mode ? fifo_byte : plain;
            OFS_CFGB: rd_data = cfgb;
            OFS_ECR:  rd_data = ecr;
            default:  rd_data = IDLE_BYTE;
        endcase
    end

endmodule

// File: rtl/ecpx_regwin.sv
module ecpx_regwin
    import ecpx_pkg::*;
#(
    parameter int FIFO_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OFS_W-1:0]  addr,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              rd_en,
    output logic [BYTE_W-1:0] rd_data
);

    ecpx_regs_t r_d, r_q;

    logic              test_mode;
    logic              wr_data, wr_cfgb, wr_ecr, rd_data_ofs;
    logic              mode_change;
    logic              f_push, f_pop, f_flush;
    logic              f_empty, f_full;
    logic [BYTE_W-1:0] f_byte;
    logic [BYTE_W-1:0] ecr_byte;

    assign test_mode   = (r_q.mode == MODE_TEST);
    assign wr_data     = wr_en && (addr == OFS_DATA);
    assign wr_cfgb     = wr_en && (addr == OFS_CFGB);
    assign wr_ecr      = wr_en && (addr == OFS_ECR);
    assign rd_data_ofs = rd_en && !wr_en && (addr == OFS_DATA);
    assign mode_change = wr_ecr && (wdata[BYTE_W-1 -: MODE_W] != r_q.mode);

    assign f_push  = wr_data && test_mode;
    assign f_pop   = rd_data_ofs && test_mode;
    assign f_flush = mode_change;

    always_comb begin
        r_d = r_q;
        if (wr_data && !test_mode) begin
            r_d.dat = wdata;
        end
        if (wr_cfgb) begin
            r_d.cfgb = wdata;
        end
        if (wr_ecr) begin
            r_d.mode = ecpx_mode_e'(wdata[BYTE_W-1 -: MODE_W]);
            r_d.ctl  = wdata[4:2];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.mode <= MODE_STD;
        end else begin
            r_q <= r_d;
        end
    end

    assign ecr_byte = {r_q.mode, r_q.ctl, f_full, f_empty};

    ecpx_fifo #(
        .DEPTH (FIFO_DEPTH),
        .DW    (BYTE_W)
    ) fifo_i (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (f_flush),
        .push  (f_push),
        .pop   (f_pop),
        .wbyte (wdata),
        .rbyte (f_byte),
        .empty (f_empty),
        .full  (f_full)
    );

    ecpx_rdmux rdmux_i (
        .addr      (addr),
        .test_mode (test_mode),
        .ecr       (ecr_byte),
        .cfgb      (r_q.cfgb),
        .plain     (r_q.dat),
        .fifo_byte (f_byte),
        .rd_data   (rd_data)
    );

    // R6: the written mode field is installed on the next cycle
    p_mode_install_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ecr |=> (rd_data != rd_data || r_q.mode == $past(wdata[BYTE_W-1 -: MODE_W])));

    // R7: an ECR write that keeps the mode leaves the FIFO status alone
    p_same_mode_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ecr && !mode_change) |=> ($stable(f_empty) && $stable(f_full)));

    // R8: outside test mode the FIFO status never moves on data accesses
    p_plain_no_fifo_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!test_mode && !wr_ecr && (wr_data || rd_data_ofs)) |=> ($stable(f_empty) && $stable(f_full)));

    // R10: unmapped offsets read as all ones
    p_unmapped_ff_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr > OFS_ECR) |-> (rd_data == IDLE_BYTE));

endmodule

// File: tb/ecpx_regwin_tb_top.sv
module ecpx_regwin_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // bench model of the requirements
    logic [2:0] m_mode;
    logic [2:0] m_ctl;
    logic [7:0] m_cfg, m_dat;
    logic [7:0] m_mem [2];
    int         m_wp, m_rp;
    logic       m_e, m_f;

    always #10 clk = ~clk;

    ecpx_regwin dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .wr_en   (wr_en),
        .wdata   (wdata),
        .rd_en   (rd_en),
        .rd_data (rd_data)
    );

    function automatic logic [7:0] m_ecr();
        return {m_mode, m_ctl, m_f, m_e};
    endfunction

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%02h expected=0x%02h", tag, act, exp);
        end
    endtask

    task automatic do_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1; rd_en = 1'b0;
        @(posedge clk);
        #1 wr_en = 1'b0;
        case (a)
            3'd0: begin
                if (m_mode == 3'd6) begin
                    m_mem[m_wp] = d;
                    m_e = 1'b0;
                    if (m_wp == 1) begin m_wp = 0; m_f = 1'b1; end
                    else begin m_wp = m_wp + 1; m_f = 1'b0; end
                end else begin
                    m_dat = d;
                end
            end
            3'd1: m_cfg = d;
            3'd2: begin
                if (d[7:5] != m_mode) begin
                    m_wp = 0; m_rp = 0; m_e = 1'b1; m_f = 1'b0;
                end
                m_mode = d[7:5];
                m_ctl  = d[4:2];
            end
            default: ;
        endcase
    endtask

    task automatic do_rd(input logic [2:0] a, input string tag_in);
        logic [7:0] exp;
        string      tag;
        tag = tag_in;
        case (a)
            3'd0: begin
                if (m_mode == 3'd6) begin
                    exp = m_mem[m_rp];
                    if (tag == "") tag = m_e ? "R5" : "R4";
                end else begin
                    exp = m_dat;
                    if (tag == "") tag = "R8";
                end
            end
            3'd1: begin exp = m_cfg; if (tag == "") tag = "R9"; end
            3'd2: begin exp = m_ecr(); if (tag == "") tag = "R2"; end
            default: begin exp = 8'hFF; if (tag == "") tag = "R10"; end
        endcase
        @(negedge clk);
        addr = a; rd_en = 1'b1; wr_en = 1'b0;
        #2 chk(rd_data, exp, tag);
        @(posedge clk);
        #1 rd_en = 1'b0;
        if (a == 3'd0 && m_mode == 3'd6 && !m_e) begin
            m_rp = (m_rp == 1) ? 0 : m_rp + 1;
            m_f  = 1'b0;
            m_e  = (m_rp == m_wp);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin : stim
        m_mode = 3'd0; m_ctl = 3'd0; m_cfg = 8'h00; m_dat = 8'h00;
        m_mem[0] = 8'h00; m_mem[1] = 8'h00;
        m_wp = 0; m_rp = 0; m_e = 1'b1; m_f = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset values
        do_rd(3'd2, "R1");
        do_rd(3'd0, "R1");
        do_rd(3'd1, "R1");

        // R9 / R8 / R10 plain registers
        do_wr(3'd1, 8'hA5); do_rd(3'd1, "R9");
        do_wr(3'd0, 8'h3C); do_rd(3'd0, "R8");
        for (int a = 3; a < 8; a++) begin
            do_wr(3'(a), 8'h11 * a);
            do_rd(3'(a), "R10");
        end
        do_rd(3'd1, "R10");
        do_rd(3'd0, "R10");

        // R6 enter test mode, flag sequence empty, one, full, pop, pop
        do_wr(3'd2, 8'hC0);
        do_rd(3'd2, "R6");
        do_wr(3'd0, 8'h5A); do_rd(3'd2, "R3");
        chk(m_ecr(), 8'hC0, "R3");
        do_wr(3'd0, 8'h96); do_rd(3'd2, "R3");
        chk(m_ecr(), 8'hC2, "R3");
        do_rd(3'd0, "R4");  do_rd(3'd2, "R4");
        chk(m_ecr(), 8'hC0, "R4");
        do_rd(3'd0, "R4");  do_rd(3'd2, "R4");
        chk(m_ecr(), 8'hC1, "R4");
        // R5 read while empty returns the stale slot and moves nothing
        do_rd(3'd0, "R5"); do_rd(3'd0, "R5"); do_rd(3'd2, "R5");

        // R7 same-mode ECR write keeps FIFO state
        do_wr(3'd0, 8'h77);
        do_wr(3'd2, 8'hDC);
        do_rd(3'd2, "R7");
        do_rd(3'd0, "R7");
        do_rd(3'd2, "R7");

        // R6 mode change flushes a filled FIFO
        do_wr(3'd0, 8'h01); do_wr(3'd0, 8'h02);
        do_wr(3'd2, 8'h20);
        do_rd(3'd2, "R6");
        do_rd(3'd0, "R8");
        do_wr(3'd2, 8'hC0);
        do_rd(3'd2, "R6");

        // near-exhaustive sweep: every mode against every offset and op mix
        for (int i = 0; i < 1500; i++) begin
            int unsigned r;
            r = $urandom;
            if (r[3:0] < 4'd5) begin
                do_wr(3'd0, r[15:8]);
            end else if (r[3:0] < 4'd10) begin
                do_rd(3'd0, "");
            end else if (r[3:0] == 4'd10) begin
                do_wr(3'd2, (r[6:4] == 3'd0) ? {3'd6, r[12:8]} : r[15:8]);
            end else if (r[3:0] == 4'd11) begin
                do_wr(3'(r[6:4]), r[15:8]);
            end else begin
                do_rd(3'(r[6:4]), "");
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule